// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind a serial memory front end and gathers the data bytes of one write transaction before they reach a 256-byte storage array. A start strobe supplies the word address. Its upper bits pick one 16-byte page, and its lower bits give the first slot inside that page. Each following byte strobe stores one byte in a small page buffer at the current slot. The slot pointer then advances and wraps within the page, so it never moves into the neighbouring page. When more than 16 bytes arrive, the later bytes replace the earlier ones in arrival order.

Nothing reaches the array until the stop strobe. A stop that follows at least one byte raises `busy_o` for a fixed number of clocks, `CYCLE_CLKS`. During that window the block walks the buffer and issues one array write for each slot that received a byte. The write-protect input is sampled with the stop strobe. When it is high, the busy window still lasts its full length but no array write is issued. All strobes that arrive while busy is high are dropped.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low, and no transaction is open.
- R2: A start strobe outside the busy window opens a transaction. It latches address bits [7:4] as the page and bits [3:0] as the first slot, and it discards any bytes already collected, including bytes from a transaction that is still open.
- R3: Each byte strobe in an open transaction stores the byte at the current slot and marks that slot as received. The slot then advances by one modulo 16, and the page bits stay unchanged.
- R4: When more than 16 bytes are sent, a slot that is reached again is overwritten, and only the last byte stored in each slot reaches the array.
- R5: No array write occurs before the stop strobe. A stop in an open transaction holding at least one byte makes `busy_o` high from the next clock edge.
- R6: `busy_o` stays high for exactly `CYCLE_CLKS` consecutive cycles, then falls.
- R7: During the busy window, each received slot is written exactly once at address {page, slot}, in ascending slot order, with `arr_we_o` high only while `busy_o` is high. Slots that received no byte are not written.
- R8: If `wprot_i` is high in the cycle of the stop strobe, the busy window keeps its full `CYCLE_CLKS` length and `arr_we_o` stays low throughout.
- R9: A stop strobe in a transaction with no byte after the address starts no busy window, issues no write and closes the transaction.
- R10: Start, byte and stop strobes that arrive while `busy_o` is high are ignored. They change neither the busy length nor the data written, and they open no transaction.
- R11: Byte and stop strobes that arrive while no transaction is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_start_i | input | 1 | Start-of-write strobe, one cycle |
| wr_addr_i | input | ADDR_W | Word address that comes with the start strobe |
| byte_vld_i | input | 1 | Data byte strobe, one cycle |
| byte_i | input | DATA_W | Data byte that comes with the byte strobe |
| stop_i | input | 1 | Stop strobe, one cycle |
| wprot_i | input | 1 | Write protect, sampled together with stop |
| busy_o | output | 1 | High during the self-timed commit window |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
The bench uses an 8-bit address, a 4-bit slot field and `CYCLE_CLKS` = 40. The short window lets each busy period be counted cycle by cycle, and the whole 256-byte array model can be compared after every transaction. The page size stays at its real value of 16, so transactions of 17 to 20 bytes and start slots near 15 are cheap to generate, which makes slot wrap and overwrite frequent. With a 40-cycle window, bench strobes injected at fixed points inside it show whether the block ignores them.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_COMMIT = 2'd2
  } pcb_state_e;
endpackage

// File: rtl/pcb_addr_track.sv
module pcb_addr_track #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  localparam int SLOTS  = 1 << PAGE_W,
  localparam int PAGE_AW = ADDR_W - PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               step_i,
  output logic [PAGE_AW-1:0] page_o,
  output logic [PAGE_W-1:0]  offs_o,
  output logic [SLOTS-1:0]   mask_o
);

  logic [PAGE_AW-1:0] page_q;
  logic [PAGE_W-1:0]  offs_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      page_q <= '0;
      offs_q <= '0;
    end else if (load_i) begin
      page_q <= addr_i[ADDR_W-1:PAGE_W];
      offs_q <= addr_i[PAGE_W-1:0];
    end else if (step_i) begin
      offs_q <= offs_q + 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (rst_i || load_i) begin
        mask_o[s] <= 1'b0;
      end else if (step_i && (offs_q == PAGE_W'(s))) begin
        mask_o[s] <= 1'b1;
      end
    end
  end

  assign page_o = page_q;
  assign offs_o = offs_q;

  AST_OFFS_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !load_i) |=> (offs_o == PAGE_W'($past(offs_o) + 1'b1))); // R3
  AST_SLOT_MARKED: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !load_i) |=> mask_o[$past(offs_o)]); // R3
  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (mask_o == '0)); // R2

endmodule

// File: rtl/pcb_page_ram.sv
module pcb_page_ram #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  localparam int SLOTS = 1 << PAGE_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [PAGE_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [SLOTS];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (re_i) begin
      rdata_o <= mem[raddr_i];
    end
  end

endmodule

// File: rtl/pcb_commit_ctl.sv
module pcb_commit_ctl
  import pcb_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int CYCLE_CLKS = 40,
  localparam int SLOTS = 1 << PAGE_W,
  localparam int CNT_W = $clog2(CYCLE_CLKS)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              data_i,
  input  logic              stop_i,
  input  logic              prot_i,
  input  logic [SLOTS-1:0]  mask_i,
  output logic              load_o,
  output logic              step_o,
  output logic              rd_en_o,
  output logic [PAGE_W-1:0] rd_idx_o,
  output logic              busy_o,
  output logic              we_o,
  output logic [PAGE_W-1:0] slot_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

  pcb_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prot_q;
  logic             we_q;
  logic [PAGE_W-1:0] slot_q;
  logic             scanning;

  assign load_o   = start_i && (state_q != ST_COMMIT);
  assign step_o   = data_i && !start_i && (state_q == ST_FILL);
  assign scanning = (state_q == ST_COMMIT) && (cnt_q < CNT_W'(SLOTS));
  assign rd_en_o  = scanning;
  assign rd_idx_o = cnt_q[PAGE_W-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      prot_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (!start_i && !data_i && stop_i) begin
            if (|mask_i) begin
              state_q <= ST_COMMIT;
              cnt_q   <= '0;
              prot_q  <= prot_i;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_COMMIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      we_q   <= 1'b0;
      slot_q <= '0;
    end else begin
      we_q   <= scanning && mask_i[rd_idx_o] && !prot_q;
      slot_q <= rd_idx_o;
    end
  end

  assign busy_o = (state_q == ST_COMMIT);
  assign we_o   = we_q;
  assign slot_o = slot_q;

  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
    we_o |-> busy_o); // R7
  AST_PROT_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && prot_q) |-> !we_o); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && (cnt_q != LAST)) |=> busy_o); // R6
  AST_BUSY_SPAN: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> ($past(cnt_q) == LAST)); // R6
  AST_NO_EMPTY_COMMIT: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_o) |-> ($past(stop_i) && ($past(mask_i) != '0))); // R9
  AST_MASK_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |=> $stable(mask_i)); // R10
  AST_SLOT_ASCEND: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_o && $past(we_o)) |-> (slot_o > $past(slot_o))); // R7

endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 4,
  parameter int CYCLE_CLKS = 40,
  localparam int SLOTS   = 1 << PAGE_W,
  localparam int PAGE_AW = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              wprot_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);

  logic               load;
  logic               step;
  logic               rd_en;
  logic [PAGE_W-1:0]  rd_idx;
  logic [PAGE_AW-1:0] page;
  logic [PAGE_W-1:0]  offs;
  logic [SLOTS-1:0]   mask;
  logic [PAGE_W-1:0]  slot;

  pcb_addr_track #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_track (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load),
    .addr_i (wr_addr_i),
    .step_i (step),
    .page_o (page),
    .offs_o (offs),
    .mask_o (mask)
  );

  pcb_page_ram #(
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W)
  ) u_ram (
    .clk_i   (clk_i),
    .we_i    (step),
    .waddr_i (offs),
    .wdata_i (byte_i),
    .re_i    (rd_en),
    .raddr_i (rd_idx),
    .rdata_o (arr_data_o)
  );

  pcb_commit_ctl #(
    .PAGE_W     (PAGE_W),
    .CYCLE_CLKS (CYCLE_CLKS)
  ) u_ctl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (wr_start_i),
    .data_i   (byte_vld_i),
    .stop_i   (stop_i),
    .prot_i   (wprot_i),
    .mask_i   (mask),
    .load_o   (load),
    .step_o   (step),
    .rd_en_o  (rd_en),
    .rd_idx_o (rd_idx),
    .busy_o   (busy_o),
    .we_o     (arr_we_o),
    .slot_o   (slot)
  );

  assign arr_addr_o = {page, slot};

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!busy_o && !arr_we_o)); // R1
  AST_WRITE_IN_PAGE: assert property (@(posedge clk_i) disable iff (rst_i)
    arr_we_o |-> $stable(page)); // R3
  AST_NO_EARLY_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> !arr_we_o); // R5

endmodule

// File: tb/page_commit_buffer_tb_top.sv
`timescale 1ns/1ps
module page_commit_buffer_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 4;
  localparam int CYC    = 40;
  localparam int SLOTS  = 1 << PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_start = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic byte_vld = 1'b0;
  logic [DATA_W-1:0] byte_d = '0;
  logic stop = 1'b0;
  logic wprot = 1'b0;
  logic busy, arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_data;

  always #4 clk = ~clk;

  page_commit_buffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .CYCLE_CLKS(CYC)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .wr_start_i(wr_start), .wr_addr_i(wr_addr),
    .byte_vld_i(byte_vld), .byte_i(byte_d), .stop_i(stop), .wprot_i(wprot),
    .busy_o(busy), .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_data_o(arr_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DATA_W-1:0] seen [DEPTH];
  logic [DATA_W-1:0] ref_arr [DEPTH];
  bit                open_m = 0;
  logic [PAGE_W-1:0] off_m;
  logic [ADDR_W-PAGE_W-1:0] page_m;
  logic [DATA_W-1:0] slot_val [SLOTS];
  bit                slot_v [SLOTS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int count_slots();
    int n = 0;
    for (int i = 0; i < SLOTS; i++) if (slot_v[i]) n++;
    return n;
  endfunction

  function automatic int array_diff();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (seen[i] !== ref_arr[i]) n++;
    return n;
  endfunction

  task automatic do_start(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    wr_start = 1'b1; wr_addr = a;
    @(negedge clk);
    wr_start = 1'b0;
    if (!busy) begin
      open_m = 1;
      page_m = a[ADDR_W-1:PAGE_W];
      off_m  = a[PAGE_W-1:0];
      for (int i = 0; i < SLOTS; i++) slot_v[i] = 0;
    end
  endtask

  task automatic do_data(input logic [DATA_W-1:0] b);
    @(negedge clk);
    byte_vld = 1'b1; byte_d = b;
    @(negedge clk);
    byte_vld = 1'b0;
    chk(!arr_we && !busy, "R5 no write before stop", int'(arr_we), 0);
    if (open_m) begin
      slot_val[off_m] = b;
      slot_v[off_m]   = 1;
      off_m = off_m + 1'b1;
    end
  endtask

  task automatic do_stop(input bit wp, input bit inject);
    bit exp_busy;
    int cnt = 0;
    int nwr = 0;
    int last_slot = -1;
    bit order_ok = 1;
    int exp_wr;
    @(negedge clk);
    stop = 1'b1; wprot = wp;
    @(negedge clk);
    stop = 1'b0; wprot = 1'b0;
    exp_busy = open_m && (count_slots() > 0);
    exp_wr = (exp_busy && !wp) ? count_slots() : 0;
    if (exp_busy && !wp)
      for (int i = 0; i < SLOTS; i++)
        if (slot_v[i]) ref_arr[{page_m, PAGE_W'(i)}] = slot_val[i];
    open_m = 0;
    if (exp_busy) begin
      while (busy && cnt < CYC + 10) begin
        cnt++;
        wr_start = 1'b0; byte_vld = 1'b0; stop = 1'b0;
        if (arr_we) begin
          nwr++;
          seen[arr_addr] = arr_data;
          if (arr_addr[ADDR_W-1:PAGE_W] != page_m || int'(arr_addr[PAGE_W-1:0]) <= last_slot)
            order_ok = 0;
          last_slot = int'(arr_addr[PAGE_W-1:0]);
        end
        if (inject && cnt == 3) begin byte_vld = 1'b1; byte_d = 8'hEE; end
        if (inject && cnt == 6) begin wr_start = 1'b1; wr_addr = 8'h00; end
        if (inject && cnt == 9) stop = 1'b1;
        @(negedge clk);
      end
      wr_start = 1'b0; byte_vld = 1'b0; stop = 1'b0;
      chk(cnt == CYC, wp ? "R8 busy length under protect" : "R6 busy length", cnt, CYC);
      chk(nwr == exp_wr, wp ? "R8 writes under protect" : "R7 write count", nwr, exp_wr);
      chk(order_ok, "R7 address and order", int'(order_ok), 1);
      chk(array_diff() == 0, "R4 array content", array_diff(), 0);
      if (inject) chk(!busy, "R10 no restart after busy", int'(busy), 0);
    end else begin
      for (int k = 0; k < 3; k++) begin
        chk(!busy && !arr_we, "R9 no commit without data", int'(busy), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [ADDR_W-1:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin seen[i] = 'x; ref_arr[i] = 'x; end
    for (int i = 0; i < SLOTS; i++) begin slot_v[i] = 0; slot_val[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(!arr_we, "R1 write strobe after reset", int'(arr_we), 0);

    // R11: byte and stop with no open transaction
    do_data(8'h55);
    do_stop(0, 0);

    // R3 R7: single byte
    do_start(8'h37); do_data(8'hA1); do_stop(0, 0);
    // R3: full page from slot 0
    do_start(8'h40);
    for (int i = 0; i < 16; i++) do_data(8'(8'h10 + i));
    do_stop(0, 0);
    // R3: wrap from slot 14
    do_start(8'h9E);
    for (int i = 0; i < 5; i++) do_data(8'(8'hC0 + i));
    do_stop(0, 0);
    // R4: 20 bytes overwrite the first four slots
    do_start(8'h23);
    for (int i = 0; i < 20; i++) do_data(8'(8'h60 + i));
    do_stop(0, 0);
    // R8: protected commit
    do_start(8'h50);
    for (int i = 0; i < 4; i++) do_data(8'hF0);
    do_stop(1, 0);
    // R9: stop right after address
    do_start(8'h77); do_stop(0, 0);
    // R2: restart drops earlier bytes
    do_start(8'h10); do_data(8'h01); do_data(8'h02); do_data(8'h03);
    do_start(8'hE8); do_data(8'hB1); do_data(8'hB2);
    do_stop(0, 0);
    // R10: strobes during busy
    do_start(8'hC4); do_data(8'h3C); do_data(8'h3D);
    do_stop(0, 1);
    do_data(8'h99); do_stop(0, 0);

    for (int t = 0; t < 30; t++) begin
      a = ADDR_W'($urandom);
      n = $urandom_range(0, 20);
      do_start(a);
      for (int i = 0; i < n; i++) do_data(DATA_W'($urandom));
      do_stop($urandom_range(0, 3) == 0, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule